// File: doc/BRIEF.md
# External Bus Controller

This block turns requests from an internal master into cycles on an external memory and peripheral bus. A request carries a byte address, write data, a two-bit byte enable and a read/write flag, and it is held under a valid/ready handshake. The block decodes the address against five programmable windows and then runs one or two bus cycles with the settings of the window that matched. Each window has its own settings:

- multiplexed bus (address and data share one port) or demultiplexed bus (separate address port);
- 8-bit or 16-bit external data width;
- number of wait states, an optional extra cycle of address-latch pulse and an optional strobe delay;
- whether an external ready line can stretch the strobe.

The external address is 16, 18, 20 or 23 bits wide. Bits from 16 upward leave on a separate upper-address output. When the width is 16 (flat mode) that output is not driven. A request that hits no window runs with a separate default setting. Pad cells stay outside the block: the data port is a pair of input and output vectors with an output enable.

Top module: `ebc_top`

## Requirements
- R1: A setting word is 9 bits: bit 8 is multiplexed mode, bit 7 is 16-bit width, bits 6:3 are the wait-state count, bit 2 adds one address-latch cycle, bit 1 adds one strobe delay cycle, and bit 0 enables ready handshaking. Window i matches when `win_en_i[i]` is set and the masked address equals `win_base_i` under `win_mask_i`. The lowest-numbered matching window wins. When no window matches, `dflt_cfg_i` is used.
- R2: In multiplexed mode, `ad_o` carries the low 16 bits of the cycle address with `ad_oe_o` high while `ale_o` is high. During a read strobe `ad_oe_o` is low. During a write, `ad_o` carries the write data.
- R3: In demultiplexed mode, `addr_o` carries the low 16 address bits for the whole cycle and stays stable while a strobe is active.
- R4: In an 8-bit window, a request with both byte enables set becomes two byte cycles. The first is at the even address with the low byte, and the second is at the odd address with the high byte. Data goes on lanes 7:0, and the returned read word holds both bytes. A request with only one byte enable set runs one byte cycle at the address of that byte.
- R5: In a 16-bit window, a request is one cycle. Address bit 0 is low exactly when byte enable 0 is set, and `bhe_n_o` is low exactly when byte enable 1 is set.
- R6: Per byte cycle, `ale_o` is high for 1 + latch-extension cycles. The strobe delay bit then adds one cycle with no latch and no strobe. `rd_n_o` or `wr_n_o` is then low for 1 + wait-state cycles, and a strobe never overlaps `ale_o`.
- R7: With ready handshaking enabled, a strobe whose wait states have expired stays low until `ready_i` is sampled high on a clock edge. With it disabled, `ready_i` has no effect on timing.
- R8: `req_ready_o` is high for one cycle, in the cycle after the last strobe ends, with both strobes high. `rsp_rdata_o` is valid in that cycle. Without ready stretching, the handshake arrives n*(3 + ext + dly + ws) cycles after acceptance, where n is the number of byte cycles.
- R9: `aw_sel_i` selects the address width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 23. The request address is masked to that width before window matching and output. `upper_oe_o` is low only when `aw_sel_i` is 0, and `upper_addr_o` carries the masked bits 22:16.
- R10: After reset, `ale_o` is low, `rd_n_o`, `wr_n_o` and `bhe_n_o` are high, and `ad_oe_o`, `upper_oe_o` (with `aw_sel_i`=0) and `req_ready_o` are low.
- R11: `rd_n_o` and `wr_n_o` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending |
| req_ready_o | output | 1 | Request completed and acknowledged |
| req_addr_i | input | 23 | Byte address |
| req_we_i | input | 1 | 1 = write |
| req_be_i | input | 2 | Byte enables (bit 0 low byte) |
| req_wdata_i | input | 16 | Write data |
| rsp_rdata_o | output | 16 | Read data, valid with req_ready_o |
| aw_sel_i | input | 2 | External address width select |
| win_en_i | input | 5 | Window enables |
| win_base_i | input | 115 | Window bases, 23 bits per window |
| win_mask_i | input | 115 | Window compare masks, 23 bits per window |
| win_cfg_i | input | 45 | Window setting words, 9 bits per window |
| dflt_cfg_i | input | 9 | Setting word used on no match |
| addr_o | output | 16 | Demultiplexed address port |
| ad_o | output | 16 | Data or multiplexed address out |
| ad_i | input | 16 | Data in |
| ad_oe_o | output | 1 | Output enable for ad_o |
| upper_addr_o | output | 7 | Address bits 22:16 |
| upper_oe_o | output | 1 | Upper address drive enable |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| bhe_n_o | output | 1 | High byte enable, active low |
| ready_i | input | 1 | External ready, active high |

## Verification
The properties assume that the request fields stay stable from the cycle `req_valid_i` rises until `req_ready_o`. They also assume that `aw_sel_i` and the window settings do not change while an access is in flight. The stimulus keeps to this by changing settings and address width only when no request is pending, and by holding every request field until its handshake. Random window settings, overlapping windows, random byte enables and addresses outside every window are mixed with directed runs in which ready is held low with and without handshaking enabled.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WS_W = 4;

  typedef struct packed {
    logic            mux;
    logic            bus16;
    logic [WS_W-1:0] ws;
    logic            ale_ext;
    logic            rw_dly;
    logic            rdy_en;
  } win_cfg_t;

  localparam int CFG_W = $bits(win_cfg_t);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DLY, S_STRB, S_HOLD} bus_st_e;
endpackage

// File: rtl/ebc_addr_mask.sv
module ebc_addr_mask #(
  parameter int AW = 23,
  parameter int LW = 16
) (
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          upper_oe_o
);
  int unsigned nbits;
  logic [AW-1:0] mask;

  always_comb begin
    case (sel_i)
      2'd0:    nbits = LW;
      2'd1:    nbits = LW + 2;
      2'd2:    nbits = LW + 4;
      default: nbits = AW;
    endcase
    for (int i = 0; i < AW; i++) mask[i] = (i < nbits);
  end

  assign addr_o     = addr_i & mask;
  assign upper_oe_o = (sel_i != 2'd0);
endmodule

// File: rtl/ebc_win_match.sv
module ebc_win_match
  import ebc_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int AW   = 23
) (
  input  logic [AW-1:0]         addr_i,
  input  logic [NWIN-1:0]       win_en_i,
  input  logic [NWIN*AW-1:0]    win_base_i,
  input  logic [NWIN*AW-1:0]    win_mask_i,
  input  logic [NWIN*CFG_W-1:0] win_cfg_i,
  input  logic [CFG_W-1:0]      dflt_cfg_i,
  output win_cfg_t              cfg_o
);
  logic [NWIN-1:0] hit;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [AW-1:0] base, mask;
    assign base   = win_base_i[g*AW +: AW];
    assign mask   = win_mask_i[g*AW +: AW];
    assign hit[g] = win_en_i[g] && ((addr_i & mask) == (base & mask));
  end

  // walk downward so the lowest index has the last word
  always_comb begin
    cfg_o = win_cfg_t'(dflt_cfg_i);
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) cfg_o = win_cfg_t'(win_cfg_i[i*CFG_W +: CFG_W]);
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic [1:0]    req_be_i,
  input  logic [DW-1:0] req_wdata_i,
  input  win_cfg_t      cfg_i,
  input  logic          ready_i,
  input  logic [DW-1:0] ad_i,
  output logic          req_ready_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [LW-1:0] addr_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          bhe_n_o
);
  localparam int BW = DW / 2;

  bus_st_e         st;
  logic [WS_W-1:0] cnt;
  win_cfg_t        cfg_q;
  logic [AW-1:0]   addr_q;
  logic            we_q, hi_q, split_q;
  logic [1:0]      be_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE;  cnt <= '0;  cfg_q <= '0;  addr_q <= '0;
      we_q <= 1'b0;  hi_q <= 1'b0;  split_q <= 1'b0;
      be_q <= '0;  wdata_q <= '0;  rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid_i) begin
          st      <= S_ADDR;
          cfg_q   <= cfg_i;
          addr_q  <= req_addr_i;
          we_q    <= req_we_i;
          be_q    <= req_be_i;
          wdata_q <= req_wdata_i;
          hi_q    <= !cfg_i.bus16 && (req_be_i == 2'b10);
          split_q <= !cfg_i.bus16 && (req_be_i == 2'b11);
          cnt     <= WS_W'(cfg_i.ale_ext);
        end
        S_ADDR: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (cfg_q.rw_dly) st <= S_DLY;
          else begin st <= S_STRB; cnt <= cfg_q.ws; end
        end
        S_DLY: begin st <= S_STRB; cnt <= cfg_q.ws; end
        S_STRB: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!cfg_q.rdy_en || ready_i) begin
            st <= S_HOLD;
            if (cfg_q.bus16)  rdata_q <= ad_i;
            else if (hi_q)    rdata_q[DW-1:BW] <= ad_i[BW-1:0];
            else              rdata_q[BW-1:0]  <= ad_i[BW-1:0];
          end
        end
        S_HOLD: begin
          if (split_q && !hi_q) begin
            hi_q <= 1'b1;
            st   <= S_ADDR;
            cnt  <= WS_W'(cfg_q.ale_ext);
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [BW-1:0] wbyte;
  logic          busy;

  always_comb begin
    bus_addr_o    = addr_q;
    bus_addr_o[0] = cfg_q.bus16 ? ~be_q[0] : hi_q;
  end

  assign wbyte       = hi_q ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];
  assign busy        = (st != S_IDLE);
  assign ale_o       = (st == S_ADDR);
  assign rd_n_o      = !((st == S_STRB) && !we_q);
  assign wr_n_o      = !((st == S_STRB) && we_q);
  assign bhe_n_o     = !(cfg_q.bus16 && be_q[1]);
  assign req_ready_o = (st == S_HOLD) && !(split_q && !hi_q);
  assign rsp_rdata_o = rdata_q;
  assign addr_o      = cfg_q.mux ? '0 : bus_addr_o[LW-1:0];

  always_comb begin
    if (cfg_q.mux && ale_o) begin
      ad_o    = DW'(bus_addr_o[LW-1:0]);
      ad_oe_o = 1'b1;
    end else begin
      ad_o    = cfg_q.bus16 ? wdata_q : {{BW{1'b0}}, wbyte};
      ad_oe_o = busy && we_q;
    end
  end
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int NWIN = 5,
  parameter int AW   = 23,
  parameter int DW   = 16,
  parameter int LW   = 16,
  localparam int UW  = AW - LW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [AW-1:0]         req_addr_i,
  input  logic                  req_we_i,
  input  logic [1:0]            req_be_i,
  input  logic [DW-1:0]         req_wdata_i,
  output logic [DW-1:0]         rsp_rdata_o,
  input  logic [1:0]            aw_sel_i,
  input  logic [NWIN-1:0]       win_en_i,
  input  logic [NWIN*AW-1:0]    win_base_i,
  input  logic [NWIN*AW-1:0]    win_mask_i,
  input  logic [NWIN*CFG_W-1:0] win_cfg_i,
  input  logic [CFG_W-1:0]      dflt_cfg_i,
  output logic [LW-1:0]         addr_o,
  output logic [DW-1:0]         ad_o,
  input  logic [DW-1:0]         ad_i,
  output logic                  ad_oe_o,
  output logic [UW-1:0]         upper_addr_o,
  output logic                  upper_oe_o,
  output logic                  ale_o,
  output logic                  rd_n_o,
  output logic                  wr_n_o,
  output logic                  bhe_n_o,
  input  logic                  ready_i
);
  logic [AW-1:0] req_addr_m, bus_addr;
  win_cfg_t      sel_cfg;

  ebc_addr_mask #(.AW(AW), .LW(LW)) u_mask (
    .sel_i(aw_sel_i), .addr_i(req_addr_i),
    .addr_o(req_addr_m), .upper_oe_o(upper_oe_o)
  );

  ebc_win_match #(.NWIN(NWIN), .AW(AW)) u_match (
    .addr_i(req_addr_m), .win_en_i(win_en_i), .win_base_i(win_base_i),
    .win_mask_i(win_mask_i), .win_cfg_i(win_cfg_i),
    .dflt_cfg_i(dflt_cfg_i), .cfg_o(sel_cfg)
  );

  ebc_seq #(.AW(AW), .DW(DW), .LW(LW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_m), .req_we_i(req_we_i), .req_be_i(req_be_i),
    .req_wdata_i(req_wdata_i), .cfg_i(sel_cfg), .ready_i(ready_i),
    .ad_i(ad_i), .req_ready_o(req_ready_o), .rsp_rdata_o(rsp_rdata_o),
    .bus_addr_o(bus_addr), .addr_o(addr_o), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .ale_o(ale_o), .rd_n_o(rd_n_o),
    .wr_n_o(wr_n_o), .bhe_n_o(bhe_n_o)
  );

  assign upper_addr_o = bus_addr[AW-1:LW];
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rd_n_o,
  input logic          wr_n_o,
  input logic          ale_o,
  input logic          ad_oe_o,
  input logic          upper_oe_o,
  input logic [1:0]    aw_sel_i,
  input logic [LW-1:0] addr_o
);
  assert_no_overlap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  assert_ack_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rd_n_o && wr_n_o && !ale_o));

  assert_strobe_after_ale_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_n_o && wr_n_o));

  assert_read_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);

  assert_flat_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_sel_i == 2'd0) |-> !upper_oe_o);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable(addr_o));
endmodule

bind ebc_top ebc_chk #(.LW(16)) u_chk (.*);

// File: tb/ebc_top_tb.sv
module ebc_top_tb;
  localparam int CLK_P = 10;
  localparam int NW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic req_valid = 0, req_we = 0, ready = 1;
  logic [22:0] req_addr = '0;
  logic [1:0] req_be = 2'b11, aw_sel = 2'd0;
  logic [15:0] req_wdata = '0, ad_i = '0;
  logic [NW-1:0] win_en = '0;
  logic [NW*23-1:0] win_base = '0, win_mask = '0;
  logic [NW*9-1:0] win_cfg = '0;
  logic [8:0] dflt_cfg = '0;
  logic req_ready, ad_oe, upper_oe, ale, rd_n, wr_n, bhe_n;
  logic [15:0] rdata, addr_p, ad_o;
  logic [6:0] upper;

  ebc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_be_i(req_be),
    .req_wdata_i(req_wdata), .rsp_rdata_o(rdata), .aw_sel_i(aw_sel),
    .win_en_i(win_en), .win_base_i(win_base), .win_mask_i(win_mask),
    .win_cfg_i(win_cfg), .dflt_cfg_i(dflt_cfg), .addr_o(addr_p), .ad_o(ad_o),
    .ad_i(ad_i), .ad_oe_o(ad_oe), .upper_addr_o(upper), .upper_oe_o(upper_oe),
    .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n), .bhe_n_o(bhe_n), .ready_i(ready)
  );

  int total = 0, bad = 0;
  logic [22:0] wb [NW];
  logic [22:0] wm [NW];
  logic [8:0]  wc [NW];
  logic [7:0] mem [int];
  logic [7:0] sh [int];
  logic cur_mux = 0, cur_b16 = 1;
  logic [22:0] lat = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdm(logic [22:0] k);
    return mem.exists(int'(k)) ? mem[int'(k)] : 8'h00;
  endfunction

  function automatic logic [7:0] rds(logic [22:0] k);
    return sh.exists(int'(k)) ? sh[int'(k)] : 8'h00;
  endfunction

  function automatic logic [22:0] amask(logic [22:0] a, logic [1:0] s);
    case (s)
      2'd0: return a & 23'h00FFFF;
      2'd1: return a & 23'h03FFFF;
      2'd2: return a & 23'h0FFFFF;
      default: return a;
    endcase
  endfunction

  function automatic logic [8:0] pick(logic [22:0] a);
    for (int i = 0; i < NW; i++)
      if (win_en[i] && ((a & wm[i]) == (wb[i] & wm[i]))) return wc[i];
    return dflt_cfg;
  endfunction

  task automatic load_cfg();
    for (int i = 0; i < NW; i++) begin
      win_base[i*23 +: 23] = wb[i];
      win_mask[i*23 +: 23] = wm[i];
      win_cfg[i*9 +: 9]    = wc[i];
    end
  endtask

  // external device model
  always @(negedge clk) begin
    if (ale) lat = {upper_oe ? upper : 7'h0, cur_mux ? ad_o : addr_p};
    if (!wr_n) begin
      if (cur_b16) begin
        if (!lat[0]) mem[int'(lat & ~23'd1)] = ad_o[7:0];
        if (!bhe_n)  mem[int'(lat | 23'd1)]  = ad_o[15:8];
      end else mem[int'(lat)] = ad_o[7:0];
    end
    ad_i <= cur_b16 ? {rdm(lat | 23'd1), rdm(lat & ~23'd1)} : {8'h00, rdm(lat)};
  end

  // one request; returns cycles to handshake, ALE cycles, first address and upper fields
  task automatic xact(input logic [22:0] a, input logic we, input logic [1:0] be,
                      input logic [15:0] wd, output logic [15:0] rd, output int cyc,
                      output int alec, output logic [15:0] afirst,
                      output logic [6:0] up, output logic upoe);
    logic [8:0] c;
    bit first = 1;
    c = pick(amask(a, aw_sel));
    cur_mux = c[8]; cur_b16 = c[7];
    cyc = 0; alec = 0; afirst = '0; up = '0; upoe = 0;
    @(negedge clk);
    req_addr = a; req_we = we; req_be = be; req_wdata = wd; req_valid = 1;
    forever begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (ale) begin
        alec++;
        if (first) begin
          afirst = cur_mux ? ad_o : addr_p; up = upper; upoe = upper_oe; first = 0;
          if (cur_mux) chk("R2", "ad_oe in latch phase", ad_oe, 1);
        end
      end
      if (!rd_n) chk("R2", "ad_oe during read", ad_oe, 0);
      if (req_ready) break;
      if (cyc > 400) begin chk("R8", "no handshake", 0, 1); break; end
    end
    rd = rdata;
    req_valid = 0;
  endtask

  task automatic run(input logic [22:0] a, input logic we, input logic [1:0] be,
                     input logic [15:0] wd, input string tag);
    logic [22:0] ma;
    logic [8:0] c;
    logic [15:0] rd, af, ea;
    logic [6:0] up;
    logic upoe;
    int cyc, alec, nb;
    ma = amask(a, aw_sel);
    c = pick(ma);
    nb = (!c[7] && be == 2'b11) ? 2 : 1;
    xact(a, we, be, wd, rd, cyc, alec, af, up, upoe);
    chk("R8", {tag, " latency"}, cyc, nb * (3 + c[2] + c[1] + c[6:3]));
    chk("R6", {tag, " ale cycles"}, alec, nb * (1 + c[2]));
    ea = ma[15:0];
    ea[0] = c[7] ? ~be[0] : (be == 2'b10);
    chk(c[7] ? "R5" : "R4", {tag, " first address"}, af, ea);
    chk("R9", {tag, " upper enable"}, upoe, aw_sel != 2'd0);
    chk("R9", {tag, " upper bits"}, up, ma[22:16]);
    if (we) begin
      if (be[0]) sh[int'(ma & ~23'd1)] = wd[7:0];
      if (be[1]) sh[int'(ma | 23'd1)]  = wd[15:8];
    end else begin
      if (be[0]) chk(c[8] ? "R2" : "R3", {tag, " read low byte"}, rd[7:0], rds(ma & ~23'd1));
      if (be[1]) chk(c[7] ? "R5" : "R4", {tag, " read high byte"}, rd[15:8], rds(ma | 23'd1));
    end
  endtask

  localparam logic [22:0] PFX [9] = '{23'h000000, 23'h010000, 23'h020000, 23'h040000,
    23'h050000, 23'h060000, 23'h100000, 23'h400000, 23'h7F0000};

  initial begin
    void'($urandom(32'h5EED));
    wb[0] = 23'h010000; wm[0] = 23'h7F0000;
    wb[1] = 23'h020000; wm[1] = 23'h7F0000;
    wb[2] = 23'h040000; wm[2] = 23'h7C0000; // covers 04..07
    wb[3] = 23'h050000; wm[3] = 23'h7F0000; // shadowed by window 2
    wb[4] = 23'h400000; wm[4] = 23'h700000;
    for (int i = 0; i < NW; i++) wc[i] = 9'h080;
    load_cfg();
    #(CLK_P*2);
    chk("R10", "ale", ale, 0);
    chk("R10", "rd_n", rd_n, 1);
    chk("R10", "wr_n", wr_n, 1);
    chk("R10", "bhe_n", bhe_n, 1);
    chk("R10", "ad_oe", ad_oe, 0);
    chk("R10", "upper_oe", upper_oe, 0);
    chk("R10", "req_ready", req_ready, 0);
    @(negedge clk); rst_n = 1;

    // directed: default setting on a miss, priority of overlapping windows
    aw_sel = 2'd3; win_en = '1;
    wc[2] = {1'b0, 1'b1, 4'd1, 3'b000};
    wc[3] = {1'b0, 1'b1, 4'd9, 3'b000};
    dflt_cfg = {1'b1, 1'b0, 4'd6, 3'b110};
    load_cfg();
    run(23'h300010, 1, 2'b11, 16'hA55A, "R1 default write");
    run(23'h300010, 0, 2'b11, 16'h0000, "R1 default read");
    run(23'h050020, 1, 2'b11, 16'h1234, "R1 priority write");
    run(23'h050020, 0, 2'b10, 16'h0000, "R1 priority read");

    // directed: ready stretching
    wc[0] = {1'b0, 1'b1, 4'd2, 3'b001};
    load_cfg();
    ready = 0; cur_mux = 0; cur_b16 = 1;
    @(negedge clk);
    req_addr = 23'h010040; req_we = 0; req_be = 2'b11; req_valid = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (req_ready) chk("R7", "early handshake while not ready", 1, 0);
    end
    chk("R7", "strobe held while not ready", rd_n, 0);
    ready = 1;
    @(negedge clk);
    chk("R7", "handshake one cycle after ready", req_ready, 1);
    req_valid = 0;
    // ready ignored when handshaking disabled
    wc[0] = {1'b0, 1'b1, 4'd2, 3'b000};
    load_cfg();
    ready = 0;
    run(23'h010040, 0, 2'b11, 16'h0, "R7 ready ignored");
    ready = 1;

    // random mix
    for (int it = 0; it < 120; it++) begin
      logic [22:0] a;
      logic [1:0] be;
      @(negedge clk);
      for (int i = 0; i < NW; i++) wc[i] = 9'($urandom);
      dflt_cfg = 9'($urandom);
      win_en = 5'($urandom) | 5'b00001;
      aw_sel = 2'($urandom);
      load_cfg();
      a = PFX[$urandom % 9] | 23'($urandom & 32'h00FE);
      be = 2'($urandom % 3) + 2'd1;
      run(a, 1, be, 16'($urandom), "random write");
      be = 2'($urandom % 3) + 2'd1;
      run(a, 0, be, 16'h0, "random read");
      if (it % 10 == 0) chk("R11", "strobes idle after access", {rd_n, wr_n}, 2'b11);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P*150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule